// File: doc/BRIEF.md
# Flash Chip Erase Sequencer

This block runs the complete chip-erase procedure for a byte-wide parallel flash memory from the host side. A one-cycle start pulse launches it. It enables the program-voltage supply first. It then programs every byte to 00H, and after that runs erase pulses, each followed by a byte-by-byte erase verify. When a byte fails verify, the sequencer issues another erase pulse and resumes verifying at that byte, not at address zero. A counter limits how many pulses it may issue.

The block drives the flash bus directly. It produces chip enable, output enable and write enable strobes, an address, write data with a drive enable, and it samples read data. The strobe widths and the wait intervals come from a clock-frequency parameter and from times given in nanoseconds or microseconds. When the sequence ends, the block writes the read-mode command, drops the supply enable, and pulses done. The error flag stays valid until the next start.

Top module: `chip_erase_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, busy, done, error and the supply enable are 0, all three bus strobes (active low) are 1, and the data drive enable is 0.
- R2: A start pulse accepted in idle sets busy and the supply enable on the next clock. The supply enable is 1 during every bus write cycle.
- R3: Before the first erase command, every address from 0 to the last is written with the program-setup code 40H, followed by a write of 00H to that address and a program wait. As a result, every byte holds 00H when erasing begins.
- R4: An erase pulse consists of two consecutive writes of 20H, followed by the erase wait. The address and the pulse count are zero before the first pulse.
- R5: After each erase pulse, the block writes the verify code A0H with the current address, waits the verify time, and reads that byte. A read of FFH on a byte other than the last advances the address and verifies again without a new pulse. A read of FFH on the last address ends the sequence with success.
- R6: A verify read other than FFH increments the pulse count and issues a new erase pulse. Verification then resumes at the same failing address.
- R7: When a failing verify brings the pulse count to MAX_PULSES, the sequence ends with error set. A final pulse that verifies completely ends without error.
- R8: At both success and error exit, the block writes 00H, then clears the supply enable and busy together with a one-cycle done pulse. Error keeps its value until the next accepted start.
- R9: Write enable stays low for at least the larger of the write-pulse and data-setup times, and high for at least the write-high time, each in whole clocks. Address and data do not change while write enable is low. Write enable and output enable are never low together.
- R10: A start pulse while busy is ignored. The running sequence completes exactly once, with unchanged pulse and verify counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a chip erase |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | Pulse limit reached; held until next start |
| vpp_en_o | output | 1 | Program-voltage supply enable |
| ce_n_o | output | 1 | Flash chip enable, active low |
| oe_n_o | output | 1 | Flash output enable, active low |
| we_n_o | output | 1 | Flash write enable, active low |
| addr_o | output | ADDR_W | Flash byte address |
| dq_out_o | output | 8 | Write data to flash |
| dq_oe_o | output | 1 | Drive enable for write data |
| dq_in_i | input | 8 | Read data from flash |

## Verification
The supply enable and busy appear one clock after the start pulse is sampled, so the bench checks them at the next falling edge. The done pulse and the final error value appear together in one cycle, and the bench polls each falling edge until it finds that cycle, then reads error in that same sample. A flash model in the bench acts on each write-enable rising edge and each output-enable rising edge, which gives cycle-exact counts of erase pulses and verify reads to compare against the expected totals. Strobe widths are measured in whole clocks at falling edges and compared with the rounded-up nanosecond limits.

// File: rtl/chip_erase_pkg.sv
package chip_erase_pkg;

    localparam logic [7:0] CODE_PROG_SETUP = 8'h40;
    localparam logic [7:0] CODE_ERASE      = 8'h20;
    localparam logic [7:0] CODE_ERASE_VFY  = 8'hA0;
    localparam logic [7:0] CODE_READ_MODE  = 8'h00;
    localparam logic [7:0] BYTE_ZERO       = 8'h00;
    localparam logic [7:0] BYTE_ERASED     = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE, S_VPP_UP,
        S_PG_SETUP, S_PG_WRITE, S_PG_WAIT,
        S_ER_SETUP, S_ER_CONFIRM, S_ER_WAIT,
        S_EV_CMD, S_EV_WAIT, S_EV_READ,
        S_EXIT_RD
    } seq_state_e;

    typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_REC} bus_phase_e;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
    } bus_op_t;

    function automatic int ns_to_cycles(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int us_to_cycles(input int us, input int mhz);
        return us * mhz;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                cnt <= load_val;
                run <= 1'b1;
            end else if (run) begin
                if (cnt <= CNT_W'(1)) begin
                    run     <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen
    import chip_erase_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int ACT_WR_CYC = 8,
    parameter int ACT_RD_CYC = 15,
    parameter int REC_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  bus_op_t           op,
    input  logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [7:0]        rdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic [7:0]        dq_in
);
    localparam int MAXC  = max2(max2(ACT_WR_CYC, ACT_RD_CYC), REC_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    bus_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic             is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            is_wr  <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
            ce_n   <= 1'b1;
            oe_n   <= 1'b1;
            we_n   <= 1'b1;
            addr_q <= '0;
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (req) begin
                    addr_q <= addr;
                    dq_out <= op.data;
                    is_wr  <= op.wr;
                    dq_oe  <= op.wr;
                    ce_n   <= 1'b0;
                    we_n   <= !op.wr;
                    oe_n   <= op.wr;
                    cnt    <= op.wr ? CNT_W'(ACT_WR_CYC - 1) : CNT_W'(ACT_RD_CYC - 1);
                    phase  <= PH_ACT;
                end
                PH_ACT: if (cnt == '0) begin
                    ce_n  <= 1'b1;
                    oe_n  <= 1'b1;
                    we_n  <= 1'b1;
                    if (!is_wr) rdata <= dq_in;
                    cnt   <= CNT_W'(REC_CYC - 1);
                    phase <= PH_REC;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                PH_REC: if (cnt == '0) begin
                    dq_oe <= 1'b0;
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chip_erase_ctrl.sv
module chip_erase_ctrl
    import chip_erase_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int CLK_MHZ     = 125,
    parameter int MAX_PULSES  = 1000,
    parameter int ERASE_US    = 10000,
    parameter int VERIFY_US   = 6,
    parameter int PROG_US     = 10,
    parameter int VPP_NS      = 100,
    parameter int WE_LOW_NS   = 60,
    parameter int WE_HIGH_NS  = 20,
    parameter int DATA_SU_NS  = 50,
    parameter int RD_ACC_NS   = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              vpp_en_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        dq_out_o,
    output logic              dq_oe_o,
    input  logic [7:0]        dq_in_i
);
    localparam int ACT_WR_CYC = max2(max2(ns_to_cycles(WE_LOW_NS, CLK_MHZ),
                                          ns_to_cycles(DATA_SU_NS, CLK_MHZ)), 1);
    localparam int ACT_RD_CYC = max2(ns_to_cycles(RD_ACC_NS, CLK_MHZ), 1);
    localparam int REC_CYC    = max2(ns_to_cycles(WE_HIGH_NS, CLK_MHZ), 1);
    localparam int VPP_CYC    = max2(ns_to_cycles(VPP_NS, CLK_MHZ), 1);
    localparam int PROG_CYC   = max2(us_to_cycles(PROG_US, CLK_MHZ), 1);
    localparam int ERASE_CYC  = max2(us_to_cycles(ERASE_US, CLK_MHZ), 1);
    localparam int VFY_CYC    = max2(us_to_cycles(VERIFY_US, CLK_MHZ), 1);
    localparam int TMR_W      = $clog2(max2(max2(ERASE_CYC, PROG_CYC),
                                            max2(VFY_CYC, VPP_CYC)) + 1);
    localparam int PULSE_W    = $clog2(MAX_PULSES + 1);

    seq_state_e         state;
    logic               issued;
    logic [ADDR_W-1:0]  cur_addr;
    logic [PULSE_W-1:0] pulses;
    logic               fail_q;

    logic               is_bus, is_wait, step_done, last_addr;
    logic               bus_done, tmr_exp;
    logic [7:0]         bus_rdata;
    bus_op_t            op;
    logic [TMR_W-1:0]   tmr_val;

    always_comb begin
        is_bus  = 1'b0;
        is_wait = 1'b0;
        op      = '{wr: 1'b1, data: CODE_READ_MODE};
        tmr_val = TMR_W'(VPP_CYC);
        case (state)
            S_VPP_UP:     begin is_wait = 1'b1; tmr_val = TMR_W'(VPP_CYC);   end
            S_PG_SETUP:   begin is_bus = 1'b1;  op.data = CODE_PROG_SETUP;   end
            S_PG_WRITE:   begin is_bus = 1'b1;  op.data = BYTE_ZERO;         end
            S_PG_WAIT:    begin is_wait = 1'b1; tmr_val = TMR_W'(PROG_CYC);  end
            S_ER_SETUP,
            S_ER_CONFIRM: begin is_bus = 1'b1;  op.data = CODE_ERASE;        end
            S_ER_WAIT:    begin is_wait = 1'b1; tmr_val = TMR_W'(ERASE_CYC); end
            S_EV_CMD:     begin is_bus = 1'b1;  op.data = CODE_ERASE_VFY;    end
            S_EV_WAIT:    begin is_wait = 1'b1; tmr_val = TMR_W'(VFY_CYC);   end
            S_EV_READ:    begin is_bus = 1'b1;  op.wr = 1'b0;                end
            S_EXIT_RD:    begin is_bus = 1'b1;  op.data = CODE_READ_MODE;    end
            default: ;
        endcase
        step_done = is_bus ? bus_done : (is_wait && tmr_exp);
        last_addr = &cur_addr;
    end

    wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(is_wait && !issued),
        .load_val(tmr_val), .expired(tmr_exp)
    );

    bus_cycle_gen #(
        .ADDR_W(ADDR_W), .ACT_WR_CYC(ACT_WR_CYC),
        .ACT_RD_CYC(ACT_RD_CYC), .REC_CYC(REC_CYC)
    ) u_bus (
        .clk(clk), .rst(rst), .req(is_bus && !issued), .op(op), .addr(cur_addr),
        .done(bus_done), .rdata(bus_rdata),
        .ce_n(ce_n_o), .oe_n(oe_n_o), .we_n(we_n_o), .addr_q(addr_o),
        .dq_out(dq_out_o), .dq_oe(dq_oe_o), .dq_in(dq_in_i)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            issued   <= 1'b0;
            cur_addr <= '0;
            pulses   <= '0;
            fail_q   <= 1'b0;
            vpp_en_o <= 1'b0;
            done_o   <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state == S_IDLE) begin
                issued <= 1'b0;
                if (start_i) begin
                    err_o    <= 1'b0;
                    vpp_en_o <= 1'b1;
                    cur_addr <= '0;
                    state    <= S_VPP_UP;
                end
            end else if (!issued) begin
                issued <= 1'b1;
            end else if (step_done) begin
                issued <= 1'b0;
                case (state)
                    S_VPP_UP:     state <= S_PG_SETUP;
                    S_PG_SETUP:   state <= S_PG_WRITE;
                    S_PG_WRITE:   state <= S_PG_WAIT;
                    S_PG_WAIT: begin
                        if (last_addr) begin
                            cur_addr <= '0;
                            pulses   <= '0;
                            state    <= S_ER_SETUP;
                        end else begin
                            cur_addr <= cur_addr + ADDR_W'(1);
                            state    <= S_PG_SETUP;
                        end
                    end
                    S_ER_SETUP:   state <= S_ER_CONFIRM;
                    S_ER_CONFIRM: state <= S_ER_WAIT;
                    S_ER_WAIT:    state <= S_EV_CMD;
                    S_EV_CMD:     state <= S_EV_WAIT;
                    S_EV_WAIT:    state <= S_EV_READ;
                    S_EV_READ: begin
                        if (bus_rdata == BYTE_ERASED) begin
                            if (last_addr) begin
                                fail_q <= 1'b0;
                                state  <= S_EXIT_RD;
                            end else begin
                                cur_addr <= cur_addr + ADDR_W'(1);
                                state    <= S_EV_CMD;
                            end
                        end else if (pulses == PULSE_W'(MAX_PULSES - 1)) begin
                            fail_q <= 1'b1;
                            state  <= S_EXIT_RD;
                        end else begin
                            pulses <= pulses + PULSE_W'(1);
                            state  <= S_ER_SETUP;
                        end
                    end
                    S_EXIT_RD: begin
                        vpp_en_o <= 1'b0;
                        done_o   <= 1'b1;
                        err_o    <= fail_q;
                        state    <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign busy_o = (state != S_IDLE);
endmodule

// File: rtl/chip_erase_chk.sv
module chip_erase_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              vpp_en_o,
    input logic              ce_n_o,
    input logic              oe_n_o,
    input logic              we_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [7:0]        dq_out_o,
    input logic              dq_oe_o
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !err_o && !vpp_en_o &&
                 ce_n_o && oe_n_o && we_n_o && !dq_oe_o));

    a_r2_supply_on_write: assert property (@(posedge clk) disable iff (rst)
        !we_n_o |-> vpp_en_o);

    a_r9_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        (!we_n_o && $past(!we_n_o)) |-> ($stable(dq_out_o) && $stable(addr_o)));

    a_r9_no_strobe_overlap: assert property (@(posedge clk) disable iff (rst)
        !(!we_n_o && !oe_n_o));

    a_r9_driven_on_write: assert property (@(posedge clk) disable iff (rst)
        !we_n_o |-> dq_oe_o);

    a_r8_done_at_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !vpp_en_o));

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> done_o);
endmodule

bind chip_erase_ctrl chip_erase_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .vpp_en_o(vpp_en_o), .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .we_n_o(we_n_o),
    .addr_o(addr_o), .dq_out_o(dq_out_o), .dq_oe_o(dq_oe_o)
);

// File: tb/sim_chip_erase_ctrl.sv
`timescale 1ns/1ps
module sim_chip_erase_ctrl;
    localparam int AW     = 3;
    localparam int NBYTES = 8;
    localparam int MAXP   = 4;
    localparam int MHZ    = 125;
    localparam int EXP_WE_LOW  = 8;   // ceil(60 ns * 125 MHz), above 50 ns setup
    localparam int EXP_WE_HIGH = 3;   // ceil(20 ns * 125 MHz)

    // {need nibbles per byte (byte i at bits 4i+3:4i), pulses, verify reads, err}
    localparam logic [55:0] VEC [5] = '{
        {32'h11111111, 8'd1, 8'd8,  8'd0},
        {32'h11113111, 8'd3, 8'd10, 8'd0},
        {32'h21111112, 8'd2, 8'd9,  8'd0},
        {32'h11911111, 8'd4, 8'd9,  8'd1},
        {32'h11111411, 8'd4, 8'd11, 8'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, err, vpp_en, ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] addr;
    logic [7:0] dq_out, dq_in;

    always #4 clk = ~clk;

    chip_erase_ctrl #(
        .ADDR_W(AW), .CLK_MHZ(MHZ), .MAX_PULSES(MAXP),
        .ERASE_US(2), .VERIFY_US(1), .PROG_US(1)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
        .err_o(err), .vpp_en_o(vpp_en), .ce_n_o(ce_n), .oe_n_o(oe_n),
        .we_n_o(we_n), .addr_o(addr), .dq_out_o(dq_out), .dq_oe_o(dq_oe),
        .dq_in_i(dq_in)
    );

    // flash model
    logic [7:0]    mem [NBYTES];
    logic [31:0]   need;
    logic [AW-1:0] vaddr = '0;
    logic [7:0]    last_cmd;
    bit model_on = 0, prog_armed = 0, erase_armed = 0, verify_mode = 0, preprog_bad = 0;
    int erase_cnt = 0, prog_cnt = 0, vreads = 0, vpp_viol = 0, done_cnt = 0;

    assign dq_in = verify_mode ? mem[vaddr] : mem[addr];

    always @(posedge we_n) begin
        if (model_on) begin
            if (!vpp_en) vpp_viol++;
            if (prog_armed) begin
                mem[addr] = mem[addr] & dq_out;
                prog_armed = 0;
                prog_cnt++;
            end else if (erase_armed) begin
                erase_armed = 0;
                if (dq_out == 8'h20) begin
                    if (erase_cnt == 0)
                        for (int i = 0; i < NBYTES; i++)
                            if (mem[i] != 8'h00) preprog_bad = 1;
                    erase_cnt++;
                    for (int i = 0; i < NBYTES; i++)
                        mem[i] = (erase_cnt >= int'(need[4*i +: 4])) ? 8'hFF : 8'h3C;
                end
            end else begin
                last_cmd = dq_out;
                case (dq_out)
                    8'h40: prog_armed = 1;
                    8'h20: erase_armed = 1;
                    8'hA0: begin verify_mode = 1; vaddr = addr; end
                    8'h00: verify_mode = 0;
                    default: ;
                endcase
            end
        end
    end

    always @(posedge oe_n) if (model_on && verify_mode) vreads++;
    always @(posedge clk) if (done) done_cnt++;

    // strobe width measurement
    int low_run = 0, high_run = 0, min_low = 1000, min_high = 1000;
    bit seen_low = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!we_n) begin
                if (seen_low && high_run > 0 && high_run < min_high) min_high = high_run;
                high_run = 0;
                low_run++;
                seen_low = 1;
            end else begin
                if (low_run > 0 && low_run < min_low) min_low = low_run;
                low_run = 0;
                high_run++;
            end
        end
    end

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_scn(input int k, input bit restart);
        logic [55:0] v;
        bit got;
        v = VEC[k];
        need = v[55:24];
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'hA5;
        erase_cnt = 0; prog_cnt = 0; vreads = 0; vpp_viol = 0; preprog_bad = 0;
        prog_armed = 0; erase_armed = 0; verify_mode = 0; last_cmd = 8'h5A;
        model_on = 1;
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy && vpp_en, "R2 busy/supply after start", {busy, vpp_en}, 3);
        if (restart) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        got = 0;
        for (int c = 0; c < 60000 && !got; c++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        check(got, "R8 done pulse", got, 1);
        check(err == v[0], "R7 error flag", err, int'(v[7:0]));
        check(erase_cnt == int'(v[23:16]), "R4 R6 R7 erase pulses", erase_cnt, int'(v[23:16]));
        check(vreads == int'(v[15:8]), "R5 R6 verify reads", vreads, int'(v[15:8]));
        check(prog_cnt == NBYTES, "R3 bytes programmed", prog_cnt, NBYTES);
        check(!preprog_bad, "R3 all 00H before erase", preprog_bad, 0);
        check(last_cmd == 8'h00, "R8 read-mode command last", last_cmd, 0);
        check(vpp_viol == 0, "R2 supply during writes", vpp_viol, 0);
        repeat (40) @(negedge clk);
        check(!busy && !vpp_en, "R8 idle after done", {busy, vpp_en}, 0);
        check(err == v[0], "R8 error held", err, int'(v[7:0]));
        check(done_cnt == 1, "R10 single completion", done_cnt, 1);
        model_on = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !vpp_en, "R1 reset status", {busy, done, err, vpp_en}, 0);
        check(ce_n && oe_n && we_n, "R1 reset strobes", {ce_n, oe_n, we_n}, 7);
        check(!dq_oe, "R1 reset drive", dq_oe, 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(!busy && !vpp_en && we_n, "R1 after release", {busy, vpp_en, we_n}, 1);

        // table-driven scenarios
        for (int k = 0; k < 5; k++) run_scn(k, 1'b0);

        // directed: start while busy is ignored (R10)
        run_scn(1, 1'b1);

        // directed: error cleared by a new start, then a clean run (R8)
        run_scn(3, 1'b0);
        run_scn(0, 1'b0);

        check(min_low >= EXP_WE_LOW, "R9 write-enable low width", min_low, EXP_WE_LOW);
        check(min_high >= EXP_WE_HIGH, "R9 write-enable high width", min_high, EXP_WE_HIGH);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule